// File: doc/BRIEF.md
# Monitoring ADC Scan Sequencer

This block walks a set of measurement channels through one shared 16-bit converter. Software configures it through a small register port: an enable bit, a rate bit that chooses a single pass or endless repetition, a sample-setting field passed straight to the converter, a per-channel skip mask, and a mask for the completion interrupt. Each channel has its own result register. The converter sits outside the block and is driven by a start/done handshake: a one-cycle start pulse with the channel index, and a later one-cycle done pulse that carries the 16-bit result.

There are three ways to stop a scan, and each takes effect at a different point. Clearing the enable bit aborts at once. Masking a channel lets its conversion in progress finish and skips the channel from the next pass on. Switching to single-pass mode lets the current pass run to its end. A single pass clears its own enable bit when it finishes and raises done status, a sticky flag and a one-cycle interrupt. Scanning only starts while at least one of two supply-valid inputs is high. While scanning is enabled, the block holds a power-up request to the internal regulator high.

Top module: `adc_scan_seq`

## Requirements
- R1: No conversion starts while `vac_ok_i` and `vbat_ok_i` are both low. The enable bit keeps its value. Once either input goes high, the pending scan runs.
- R2: With CTRL bit1 = 1 (single pass) and CTRL bit0 = 1 (enable), every unmasked channel is converted once. When the pass ends, CTRL bit0 reads 0 and no further start pulses follow.
- R3: With CTRL bit1 = 0 (continuous), passes repeat over the unmasked channels for as long as the enable bit stays set.
- R4: Channels are started in ascending index order. A channel whose bit is set in CFG bits[7:0] is never started. A channel that has never been converted reads zero at address 8+index.
- R5: If a channel is masked while its conversion is in flight, its result is still stored. From the next pass on, the channel is skipped.
- R6: In single-pass mode, if every channel is masked, CTRL bit0 is cleared without any conversion.
- R7: When a single pass ends, STAT bit0 (done status) and STAT bit1 (done flag) are set. `irq_o` pulses for exactly one cycle unless CFG bit8 (done mask) is set.
- R8: In continuous mode, STAT bit0 reads 0, the done flag is left as it was, and no interrupt is raised. A read of STAT clears the done flag.
- R9: A write of 0 to CTRL bit0 aborts the scan at once. The result in flight is dropped and all result registers keep their previous values.
- R10: If the mode changes from continuous to single pass during a scan, scanning stops after the last unmasked channel of the current pass.
- R11: If all channels are masked during continuous scanning, the conversion in flight completes and is stored. No further conversion starts, and the enable bit stays set.
- R12: `reg_pwr_req_o` is high exactly while the enable bit is set. `conv_setting_o` equals CTRL bits[3:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vac_ok_i | input | 1 | Input-side supply valid |
| vbat_ok_i | input | 1 | Battery-side supply valid |
| host_we_i | input | 1 | Register write strobe |
| host_re_i | input | 1 | Register read strobe (clears the flag on a STAT read) |
| host_addr_i | input | 4 | Register address: 0 CTRL, 1 CFG, 2 STAT, 8..15 results |
| host_wdata_i | input | 16 | Write data |
| host_rdata_o | output | 16 | Read data, combinational from address |
| conv_start_o | output | 1 | One-cycle conversion start |
| conv_chan_o | output | 3 | Channel being converted |
| conv_setting_o | output | 2 | Sample setting for the converter |
| conv_done_i | input | 1 | One-cycle conversion done |
| conv_data_i | input | 16 | Conversion result, valid with done |
| irq_o | output | 1 | Completion interrupt pulse |
| reg_pwr_req_o | output | 1 | Regulator power-up request |

## Verification
A sequencer whose channel pointer or state is wrong shows up at the very next start pulse. It may start a channel out of order, start a masked index, or go silent while enabled. The bench logs the index of every start and compares the log against the ascending list it builds from the mask. A wrong stop decision shows within one conversion time. Such a decision could be an abort that stores the dropped sample, a single pass that runs into a second pass, or a continuous scan that restarts after all channels are masked. It appears as an extra start, a missing start, or a result register that differs from the last value the converter model delivered.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_START = 2'd1,
    S_WAIT  = 2'd2
  } seq_state_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_OS_BIT  = 1;
  localparam int CTRL_SMP_LSB = 2;
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int DW   = 16,
  parameter int SW   = 2,
  parameter int CH_W = 3,
  parameter int AW   = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic            re_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            en_o,
  output logic            oneshot_o,
  output logic [SW-1:0]   samp_o,
  output logic [NCH-1:0]  dis_o,
  input  logic            res_we_i,
  input  logic [CH_W-1:0] res_ch_i,
  input  logic [DW-1:0]   res_data_i,
  input  logic            done_evt_i,
  input  logic            clr_en_i,
  output logic            irq_o
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_CFG  = AW'(1);
  localparam logic [AW-1:0] A_STAT = AW'(2);

  logic en_q, os_q, mask_q, stat_q, flag_q, irq_q;
  logic [SW-1:0]  samp_q;
  logic [NCH-1:0] dis_q;
  logic [DW-1:0]  res_q [NCH];

  logic ctrl_wr, cfg_wr, stat_rd;
  assign ctrl_wr = we_i && (addr_i == A_CTRL);
  assign cfg_wr  = we_i && (addr_i == A_CFG);
  assign stat_rd = re_i && (addr_i == A_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      os_q   <= 1'b0;
      samp_q <= '0;
      dis_q  <= '0;
      mask_q <= 1'b0;
      stat_q <= 1'b0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      // host write wins over self-clear in the same cycle
      if (ctrl_wr) begin
        en_q   <= wdata_i[CTRL_EN_BIT];
        os_q   <= wdata_i[CTRL_OS_BIT];
        samp_q <= wdata_i[CTRL_SMP_LSB +: SW];
      end else if (clr_en_i) begin
        en_q <= 1'b0;
      end
      if (cfg_wr) begin
        dis_q  <= wdata_i[NCH-1:0];
        mask_q <= wdata_i[NCH];
      end
      if (done_evt_i)                            stat_q <= 1'b1;
      else if (ctrl_wr && wdata_i[CTRL_EN_BIT])  stat_q <= 1'b0;
      if (done_evt_i)   flag_q <= 1'b1;
      else if (stat_rd) flag_q <= 1'b0;
      irq_q <= done_evt_i && !mask_q;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_res
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     res_q[g] <= '0;
      else if (res_we_i && (res_ch_i == CH_W'(g)))     res_q[g] <= res_data_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i[AW-1]) begin
      rdata_o = res_q[addr_i[CH_W-1:0]];
    end else begin
      case (addr_i)
        A_CTRL: begin
          rdata_o[CTRL_EN_BIT]          = en_q;
          rdata_o[CTRL_OS_BIT]          = os_q;
          rdata_o[CTRL_SMP_LSB +: SW]   = samp_q;
        end
        A_CFG: begin
          rdata_o[NCH-1:0] = dis_q;
          rdata_o[NCH]     = mask_q;
        end
        A_STAT: begin
          rdata_o[0] = stat_q && os_q;
          rdata_o[1] = flag_q;
        end
        default: rdata_o = '0;
      endcase
    end
  end

  assign en_o      = en_q;
  assign oneshot_o = os_q;
  assign samp_o    = samp_q;
  assign dis_o     = dis_q;
  assign irq_o     = irq_q;

  p_done_clears_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_evt_i && !ctrl_wr) |=> !en_q);
  p_irq_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  p_flag_read_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !done_evt_i) |=> !flag_q);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int CH_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            oneshot_i,
  input  logic [NCH-1:0]  dis_i,
  input  logic            sup_ok_i,
  input  logic            conv_done_i,
  output logic            start_o,
  output logic [CH_W-1:0] ch_o,
  output logic            res_we_o,
  output logic            done_evt_o,
  output logic            clr_en_o
);
  seq_state_e state_q, state_d;
  logic [CH_W-1:0] ch_q, ch_d;
  logic [NCH-1:0]  act;
  logic            any_act, nxt_found;
  logic [CH_W-1:0] first_ch, nxt_ch;

  assign act     = ~dis_i;
  assign any_act = |act;

  // lowest active channel overall, and lowest active channel above ch_q
  always_comb begin
    first_ch  = '0;
    nxt_ch    = '0;
    nxt_found = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (act[i]) first_ch = CH_W'(i);
      if (act[i] && (i > int'(ch_q))) begin
        nxt_ch    = CH_W'(i);
        nxt_found = 1'b1;
      end
    end
  end

  always_comb begin
    state_d    = state_q;
    ch_d       = ch_q;
    res_we_o   = 1'b0;
    done_evt_o = 1'b0;
    clr_en_o   = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (en_i && oneshot_i && !any_act) begin
          clr_en_o = 1'b1;
        end else if (en_i && sup_ok_i && any_act) begin
          ch_d    = first_ch;
          state_d = S_START;
        end
      end
      S_START: begin
        state_d = (en_i && sup_ok_i) ? S_WAIT : S_IDLE;
      end
      S_WAIT: begin
        if (!en_i || !sup_ok_i) begin
          state_d = S_IDLE;
        end else if (conv_done_i) begin
          res_we_o = 1'b1;
          if (nxt_found) begin
            ch_d    = nxt_ch;
            state_d = S_START;
          end else if (oneshot_i) begin
            done_evt_o = 1'b1;
            clr_en_o   = 1'b1;
            state_d    = S_IDLE;
          end else if (any_act) begin
            ch_d    = first_ch;
            state_d = S_START;
          end else begin
            state_d = S_IDLE;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ch_q    <= '0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
    end
  end

  assign start_o = (state_q == S_START);
  assign ch_o    = ch_q;

  p_idle_no_supply_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sup_ok_i |=> (state_q == S_IDLE));
  p_abort_now_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == S_IDLE));
  p_skip_masked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == S_START) && ($past(state_q) == S_WAIT))
      |-> (($past(dis_i) & (NCH'(1) << ch_q)) == '0));
  p_store_only_in_wait_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_we_o |-> ($past(state_q) != S_IDLE));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter  int NCH  = 8,
  parameter  int DW   = 16,
  parameter  int SW   = 2,
  localparam int CH_W = $clog2(NCH),
  localparam int AW   = CH_W + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            vac_ok_i,
  input  logic            vbat_ok_i,
  input  logic            host_we_i,
  input  logic            host_re_i,
  input  logic [AW-1:0]   host_addr_i,
  input  logic [DW-1:0]   host_wdata_i,
  output logic [DW-1:0]   host_rdata_o,
  output logic            conv_start_o,
  output logic [CH_W-1:0] conv_chan_o,
  output logic [SW-1:0]   conv_setting_o,
  input  logic            conv_done_i,
  input  logic [DW-1:0]   conv_data_i,
  output logic            irq_o,
  output logic            reg_pwr_req_o
);
  logic            en, oneshot, res_we, done_evt, clr_en;
  logic [NCH-1:0]  dis;
  logic [CH_W-1:0] ch;

  adc_seq_regs #(.NCH(NCH), .DW(DW), .SW(SW), .CH_W(CH_W), .AW(AW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (host_we_i),
    .re_i       (host_re_i),
    .addr_i     (host_addr_i),
    .wdata_i    (host_wdata_i),
    .rdata_o    (host_rdata_o),
    .en_o       (en),
    .oneshot_o  (oneshot),
    .samp_o     (conv_setting_o),
    .dis_o      (dis),
    .res_we_i   (res_we),
    .res_ch_i   (ch),
    .res_data_i (conv_data_i),
    .done_evt_i (done_evt),
    .clr_en_i   (clr_en),
    .irq_o      (irq_o)
  );

  adc_seq_ctrl #(.NCH(NCH), .CH_W(CH_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .oneshot_i   (oneshot),
    .dis_i       (dis),
    .sup_ok_i    (vac_ok_i || vbat_ok_i),
    .conv_done_i (conv_done_i),
    .start_o     (conv_start_o),
    .ch_o        (ch),
    .res_we_o    (res_we),
    .done_evt_o  (done_evt),
    .clr_en_o    (clr_en)
  );

  assign conv_chan_o   = ch;
  assign reg_pwr_req_o = en;
endmodule

// File: tb/adc_scan_seq_test.sv
`timescale 1ns/1ps
module adc_scan_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vac = 1'b1, vbat = 1'b1;
  logic we = 1'b0, re = 1'b0;
  logic [3:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic cstart, cdone = 1'b0, irq, preq;
  logic [2:0] cchan;
  logic [1:0] cset;
  logic [15:0] cdata = '0;

  always #4 clk = ~clk;

  adc_scan_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .vac_ok_i(vac), .vbat_ok_i(vbat),
    .host_we_i(we), .host_re_i(re), .host_addr_i(addr), .host_wdata_i(wdata),
    .host_rdata_o(rdata), .conv_start_o(cstart), .conv_chan_o(cchan),
    .conv_setting_o(cset), .conv_done_i(cdone), .conv_data_i(cdata),
    .irq_o(irq), .reg_pwr_req_o(preq)
  );

  int total = 0, fails = 0;
  int log_ch [4096];
  int nlog = 0;
  int conv_lat = 0;
  bit accept = 1'b1;
  logic [15:0] exp_r [8];
  logic [1:0] last_set = '0;
  int irq_cnt = 0, irq_long = 0;
  logic [12:0] seq = '0;
  bit done_flag_ok;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // converter model
  initial begin
    forever begin
      @(negedge clk);
      cdone = 1'b0;
      if (cstart) begin
        automatic int c = int'(cchan);
        automatic int l;
        log_ch[nlog] = c;
        nlog++;
        last_set = cset;
        l = (conv_lat > 0) ? conv_lat : 1 + int'($urandom % 4);
        repeat (l) @(negedge clk);
        seq++;
        cdata = {c[2:0], seq};
        cdone = 1'b1;
        if (accept) exp_r[c] = cdata;
      end
    end
  end

  initial begin
    logic prev = 1'b0;
    forever begin
      @(negedge clk);
      if (irq) irq_cnt++;
      if (irq && prev) irq_long++;
      prev = irq;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); re = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    logic [15:0] d;
    for (int i = 0; i < 3000; i++) begin
      rd(4'd0, d);
      if (!d[0]) return;
    end
    chk({tag, " single pass end"}, 1, 0);
  endtask

  task automatic check_order(input string tag, input logic [7:0] mask, input int base);
    int k = base;
    for (int i = 0; i < 8; i++) begin
      if (!mask[i]) begin
        chk({tag, " order"}, log_ch[k], i);
        k++;
      end
    end
    chk({tag, " start count"}, nlog, k);
  endtask

  task automatic check_results(input string tag);
    logic [15:0] d;
    for (int i = 0; i < 8; i++) begin
      rd(4'(8 + i), d);
      chk(tag, d, exp_r[i]);
    end
  endtask

  initial begin
    logic [15:0] d;
    logic [7:0] m;
    logic [15:0] old;
    int ic;
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) exp_r[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(4'd0, d); chk("R2 reset ctrl", d, 0);
    rd(4'd1, d); chk("R4 reset cfg", d, 0);
    rd(4'd2, d); chk("R7 reset stat", d, 0);
    check_results("R4 reset results zero");
    chk("R12 reset pwr req", preq, 0);
    chk("R7 reset irq", irq, 0);

    // masked single pass: skipped channels keep zero
    m = 8'($urandom % 255);
    nlog = 0;
    wr(4'd1, {8'h00, m});
    wr(4'd0, 16'h000B);
    @(negedge clk); chk("R12 pwr req while enabled", preq, 1);
    chk("R12 setting passthrough", cset, 2'b10);
    wait_idle("R2");
    check_order("R4 masked pass", m, 0);
    check_results("R4 masked results");
    chk("R12 setting at converter", last_set, 2'b10);
    chk("R12 pwr req released", preq, 0);
    rd(4'd2, d); chk("R7 stat and flag set", d[1:0], 2'b11);
    chk("R7 one irq", irq_cnt, 1);
    rd(4'd2, d); chk("R8 flag cleared by read", d[1:0], 2'b01);

    // done mask suppresses irq
    nlog = 0;
    wr(4'd1, 16'h0100);
    wr(4'd0, 16'h0003);
    wait_idle("R2");
    check_order("R2 full pass", 8'h00, 0);
    chk("R7 masked irq", irq_cnt, 1);
    rd(4'd2, d); chk("R7 flag with mask", d[1:0], 2'b11);
    check_results("R2 results");

    // continuous then switch to single pass
    wr(4'd1, 16'h0000);
    nlog = 0;
    wr(4'd0, 16'h0001);
    while (nlog < 20) @(negedge clk);
    for (int k = 0; k < 16; k++) chk("R3 repeated order", log_ch[k], k % 8);
    rd(4'd2, d); chk("R8 continuous stat zero, flag kept", d[1:0], 2'b00);
    chk("R8 no irq in continuous", irq_cnt, 1);
    wr(4'd0, 16'h0003);
    wait_idle("R10");
    chk("R10 last channel", log_ch[nlog-1], 7);
    chk("R10 whole passes", nlog % 8, 0);
    rd(4'd2, d); chk("R10 done after switch", d[1:0], 2'b11);
    check_results("R10 results");

    // abort: in-flight sample dropped
    conv_lat = 20;
    nlog = 0;
    wr(4'd0, 16'h0001);
    while (nlog < 3) @(negedge clk);
    accept = 1'b0;
    old = exp_r[2];
    repeat (2) @(negedge clk);
    wr(4'd0, 16'h0000);
    repeat (40) @(negedge clk);
    chk("R9 no start after abort", nlog, 3);
    rd(4'(10), d); chk("R9 dropped sample", d, old);
    check_results("R9 results kept");
    accept = 1'b1;

    // mask a channel while it converts
    conv_lat = 15;
    nlog = 0;
    old = exp_r[3];
    wr(4'd0, 16'h0003);
    while (nlog < 4) @(negedge clk);
    wr(4'd1, 16'h0008);
    wait_idle("R5");
    chk("R5 pass finished", nlog, 8);
    rd(4'(11), d); chk("R5 in-flight stored", d, exp_r[3]);
    chk("R5 fresh sample", (exp_r[3] != old), 1);
    conv_lat = 0;
    nlog = 0;
    wr(4'd0, 16'h0003);
    wait_idle("R5");
    check_order("R5 skipped next pass", 8'h08, 0);

    // mask all during continuous
    conv_lat = 15;
    wr(4'd1, 16'h0000);
    nlog = 0;
    old = exp_r[1];
    wr(4'd0, 16'h0001);
    while (nlog < 2) @(negedge clk);
    wr(4'd1, 16'h00FF);
    repeat (60) @(negedge clk);
    chk("R11 stopped", nlog, 2);
    rd(4'd9, d); chk("R11 last stored", d, exp_r[1]);
    chk("R11 fresh sample", (exp_r[1] != old), 1);
    rd(4'd0, d); chk("R11 enable kept", d[0], 1);
    wr(4'd0, 16'h0000);
    conv_lat = 0;

    // single pass with all masked
    nlog = 0;
    wr(4'd0, 16'h0003);
    repeat (4) @(negedge clk);
    rd(4'd0, d); chk("R6 enable cleared", d[0], 0);
    chk("R6 no conversion", nlog, 0);

    // supply gating
    wr(4'd1, 16'h0000);
    vac = 1'b0; vbat = 1'b0;
    nlog = 0;
    wr(4'd0, 16'h0003);
    repeat (30) @(negedge clk);
    chk("R1 no start without supply", nlog, 0);
    rd(4'd0, d); chk("R1 enable held", d[0], 1);
    vbat = 1'b1;
    wait_idle("R1");
    chk("R1 scan after supply", nlog, 8);
    vac = 1'b1;

    // random single passes
    for (int t = 0; t < 6; t++) begin
      logic [1:0] s;
      m = 8'($urandom % 255);
      s = 2'($urandom);
      ic = irq_cnt;
      nlog = 0;
      wr(4'd1, {8'h00, m});
      wr(4'd0, {12'h000, s, 2'b11});
      wait_idle("R2");
      check_order("R4 random pass", m, 0);
      check_results("R4 random results");
      chk("R12 random setting", last_set, s);
      chk("R7 random irq", irq_cnt, ic + 1);
      rd(4'd2, d);
    end
    chk("R7 irq width", irq_long, 0);

    finish_run();
  end
endmodule